// File: doc/BRIEF.md
# Slave Serial Configuration Loader

This block loads a configuration image into a target programmable device over a slave-serial link. When a start request arrives with a byte count, it switches on the target's supply, waits for the supply to settle, and holds the program line low for a set time. It then waits for the target to report that it is ready, with a limit on how long it waits. Next it takes image bytes from a valid/ready stream and shifts each byte out, most significant bit first, on a data line with its own clock. After the last byte it keeps pulsing the clock until the target reports that it has finished, again with a limit.

All delays and limits are parameters counted in system clocks. The defaults are about 50 ms of settle and program time at 200 MHz and 100000 polls or pulses, so a test can use much shorter values. At the end of a run the block raises exactly one result flag: success, a ready timeout, or a finish timeout. The flag stays up until the next accepted start. A source that reports an error ends the shifting early, and the block moves straight on to the finish clocking.

Top module: `slave_serial_loader`

## Requirements
- R1: After reset: supply enable 0, program line 1, configuration clock 0, data 0, busy 0, all result flags 0, ready 0.
- R2: A start taken while idle sets busy and the supply enable at the next edge. The supply is on for exactly SETTLE_CYC cycles before the program line falls. The program line then stays low for exactly PROG_CYC cycles and returns high.
- R3: After the program line is released, the target-ready input is sampled once per cycle. If it is high in one of the first INIT_POLLS samples, loading continues. Otherwise err_init_timeout is set, busy ends, and the configuration clock never rises.
- R4: Bytes leave most significant bit first. The data bit is placed at least one cycle before the clock rises and does not change on that rising edge. The clock is high for exactly one cycle and low for at least one cycle between rises.
- R5: Ready is high only during the shift phase, while no bit is in flight and bytes are still owed. A byte is taken on valid and ready together, and exactly byte_count bytes are shifted.
- R6: A source error seen while ready is high ends the shift phase at once, takes precedence over valid in the same cycle, and leads to finish clocking. Only the bytes taken before the error are shifted.
- R7: In the finish phase the target-done input is tested before each extra clock pulse, and the block reports success as soon as it is high. After DONE_TOGGLES pulses without done, err_done_timeout is set. When done arrives with the last allowed pulse, success wins.
- R8: Exactly one result flag is set at the end of each run. It holds until the next accepted start, which clears all flags. Busy lasts from the accepted start to the end of the run.
- R9: A start request while busy is ignored: the running load keeps its own byte count.
- R10: A byte count of zero skips shifting and goes straight to finish clocking once the target is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only while idle |
| byte_count_i | input | CNT_W | Number of image bytes to shift |
| din_valid_i | input | 1 | Image byte available |
| din_data_i | input | 8 | Image byte |
| din_ready_o | output | 1 | Loader can take a byte this cycle |
| src_err_i | input | 1 | Image source failure, ends shifting |
| tgt_init_i | input | 1 | Target ready to receive the image |
| tgt_done_i | input | 1 | Target reports configuration complete |
| tgt_pwr_en_o | output | 1 | Target supply enable |
| cfg_prog_n_o | output | 1 | Active-low program line |
| cfg_clk_o | output | 1 | Configuration clock |
| cfg_data_o | output | 1 | Configuration data bit |
| busy_o | output | 1 | A load is in progress |
| done_ok_o | output | 1 | Last run finished with target done |
| err_init_timeout_o | output | 1 | Last run gave up waiting for target ready |
| err_done_timeout_o | output | 1 | Last run gave up waiting for target done |

## Verification
Two decisions can fall in the same cycle. The first is the finish test at the end of the pulse budget: the bench raises done exactly as the last allowed pulse goes out and expects success, and it raises done one pulse later and expects a finish timeout with exactly DONE_TOGGLES pulses. The second is the handshake cycle in which the source raises valid and error together: the bench expects the error to win, so the byte offered in that cycle must never show up on the data line. The ready wait is probed in the same way, with ready arriving on the last allowed sample and then one sample too late.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POWER,
    ST_PROG,
    ST_WAIT_INIT,
    ST_SHIFT,
    ST_FINISH
  } ssl_state_e;
endpackage

// File: rtl/ssl_interval_timer.sv
module ssl_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else if (en_i)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ssl_bit_shifter.sv
module ssl_bit_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              pulse_i,
  output logic              idle_o,
  output logic              cclk_o,
  output logic              cdata_o
);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_HIGH} ph_e;

  ph_e               ph_q;
  logic [BYTE_W-1:0] sh_q;
  logic [IDX_W-1:0]  left_q;

  assign idle_o = (ph_q == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      cclk_o  <= 1'b0;
      cdata_o <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (load_i) begin
            cdata_o <= byte_i[BYTE_W-1];
            sh_q    <= byte_i << 1;
            left_q  <= IDX_W'(BYTE_W-1);
            ph_q    <= PH_SETUP;
          end else if (pulse_i) begin
            cclk_o <= 1'b1;
            left_q <= '0;
            ph_q   <= PH_HIGH;
          end
        end
        PH_SETUP: begin
          cclk_o <= 1'b1;
          ph_q   <= PH_HIGH;
        end
        PH_HIGH: begin
          cclk_o <= 1'b0;
          if (left_q == '0) begin
            ph_q <= PH_IDLE;
          end else begin
            cdata_o <= sh_q[BYTE_W-1];
            sh_q    <= sh_q << 1;
            left_q  <= left_q - 1'b1;
            ph_q    <= PH_SETUP;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R4: the clock high phase is a single system cycle
  assert_clk_single_high_R4: assert property (@(posedge clk) disable iff (rst)
    cclk_o |=> !cclk_o);

  // R4: the data bit is already in place when the clock rises
  assert_data_before_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk_o) |-> $stable(cdata_o));

  // R5: a new byte only arrives when no bit is in flight
  assert_load_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (ph_q == PH_IDLE));
endmodule

// File: rtl/slave_serial_loader.sv
module slave_serial_loader
  import ssl_pkg::*;
#(
  parameter int CNT_W        = 24,
  parameter int SETTLE_CYC   = 10_000_000,
  parameter int PROG_CYC     = 10_000_000,
  parameter int INIT_POLLS   = 100_000,
  parameter int DONE_TOGGLES = 100_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic             din_valid_i,
  input  logic [7:0]       din_data_i,
  output logic             din_ready_o,
  input  logic             src_err_i,
  input  logic             tgt_init_i,
  input  logic             tgt_done_i,
  output logic             tgt_pwr_en_o,
  output logic             cfg_prog_n_o,
  output logic             cfg_clk_o,
  output logic             cfg_data_o,
  output logic             busy_o,
  output logic             done_ok_o,
  output logic             err_init_timeout_o,
  output logic             err_done_timeout_o
);
  localparam int TMR_W = $clog2(SETTLE_CYC + PROG_CYC + INIT_POLLS + DONE_TOGGLES + 2);
  localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] PROG_LAST   = TMR_W'(PROG_CYC - 1);
  localparam logic [TMR_W-1:0] INIT_LAST   = TMR_W'(INIT_POLLS - 1);
  localparam logic [TMR_W-1:0] DONE_LIM    = TMR_W'(DONE_TOGGLES);

  ssl_state_e       state_q;
  logic [CNT_W-1:0] bytes_left_q;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_clr, tmr_en;
  logic             sh_load, sh_pulse, sh_idle;

  ssl_interval_timer #(.W(TMR_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .cnt_o (tmr_cnt)
  );

  ssl_bit_shifter #(.BYTE_W(8)) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .load_i  (sh_load),
    .byte_i  (din_data_i),
    .pulse_i (sh_pulse),
    .idle_o  (sh_idle),
    .cclk_o  (cfg_clk_o),
    .cdata_o (cfg_data_o)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign din_ready_o = (state_q == ST_SHIFT) && sh_idle && (bytes_left_q != '0);

  always_comb begin
    tmr_clr  = 1'b0;
    tmr_en   = 1'b0;
    sh_load  = 1'b0;
    sh_pulse = 1'b0;
    case (state_q)
      ST_IDLE: tmr_clr = 1'b1;
      ST_POWER: begin
        if (tmr_cnt == SETTLE_LAST) tmr_clr = 1'b1;
        else                        tmr_en  = 1'b1;
      end
      ST_PROG: begin
        if (tmr_cnt == PROG_LAST) tmr_clr = 1'b1;
        else                      tmr_en  = 1'b1;
      end
      ST_WAIT_INIT: begin
        if (tgt_init_i || tmr_cnt == INIT_LAST) tmr_clr = 1'b1;
        else                                    tmr_en  = 1'b1;
      end
      ST_SHIFT: begin
        tmr_clr = 1'b1;
        sh_load = din_ready_o && din_valid_i && !src_err_i;
      end
      ST_FINISH: begin
        if (sh_idle && !tgt_done_i && tmr_cnt != DONE_LIM) begin
          sh_pulse = 1'b1;
          tmr_en   = 1'b1;
        end
      end
      default: tmr_clr = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q            <= ST_IDLE;
      bytes_left_q       <= '0;
      tgt_pwr_en_o       <= 1'b0;
      cfg_prog_n_o       <= 1'b1;
      done_ok_o          <= 1'b0;
      err_init_timeout_o <= 1'b0;
      err_done_timeout_o <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q            <= ST_POWER;
            tgt_pwr_en_o       <= 1'b1;
            bytes_left_q       <= byte_count_i;
            done_ok_o          <= 1'b0;
            err_init_timeout_o <= 1'b0;
            err_done_timeout_o <= 1'b0;
          end
        end
        ST_POWER: begin
          if (tmr_cnt == SETTLE_LAST) begin
            cfg_prog_n_o <= 1'b0;
            state_q      <= ST_PROG;
          end
        end
        ST_PROG: begin
          if (tmr_cnt == PROG_LAST) begin
            cfg_prog_n_o <= 1'b1;
            state_q      <= ST_WAIT_INIT;
          end
        end
        ST_WAIT_INIT: begin
          if (tgt_init_i) begin
            state_q <= ST_SHIFT;
          end else if (tmr_cnt == INIT_LAST) begin
            err_init_timeout_o <= 1'b1;
            state_q            <= ST_IDLE;
          end
        end
        ST_SHIFT: begin
          if (din_ready_o && src_err_i)         state_q      <= ST_FINISH;
          else if (sh_load)                     bytes_left_q <= bytes_left_q - 1'b1;
          else if (sh_idle && bytes_left_q == '0) state_q    <= ST_FINISH;
        end
        ST_FINISH: begin
          if (sh_idle) begin
            if (tgt_done_i) begin
              done_ok_o <= 1'b1;
              state_q   <= ST_IDLE;
            end else if (tmr_cnt == DONE_LIM) begin
              err_done_timeout_o <= 1'b1;
              state_q            <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: at most one outcome is ever reported
  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_ok_o, err_init_timeout_o, err_done_timeout_o}));

  // R8: a new run starts with a clean result
  assert_flags_clear_on_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !(done_ok_o || err_init_timeout_o || err_done_timeout_o));

  // R2: the program pulse only happens with the supply on
  assert_prog_needs_power_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_prog_n_o |-> tgt_pwr_en_o);

  // R3: no clock activity before the target reports ready
  assert_quiet_before_init_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {ST_POWER, ST_PROG, ST_WAIT_INIT}) |-> !cfg_clk_o);

  // R5: ready is only offered while the clock rests low
  assert_ready_clock_low_R5: assert property (@(posedge clk) disable iff (rst)
    din_ready_o |-> !cfg_clk_o);

  // R7: the finish phase never exceeds its pulse budget
  assert_toggle_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FINISH) |-> (tmr_cnt <= DONE_LIM));

  // R9: a start during the early phases leaves the owed count alone
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (start_i && state_q inside {ST_POWER, ST_PROG, ST_WAIT_INIT}) |=> $stable(bytes_left_q));
endmodule

// File: tb/sim_slave_serial_loader.sv
module sim_slave_serial_loader;
  localparam int CNT_W  = 8;
  localparam int SETTLE = 6;
  localparam int PROG   = 4;
  localparam int INIT_P = 12;
  localparam int DONE_T = 10;
  localparam int NVEC   = 9;
  localparam int NEVER  = 255;

  // columns: bytes, gap, init delay, done after pulses, error index, restart poke, result (0 ok, 1 init TO, 2 done TO)
  localparam int VEC [0:NVEC-1][0:6] = '{
    '{3, 0, 0,  0,     NEVER, 0, 0},
    '{5, 2, 3,  4,     NEVER, 1, 0},
    '{1, 0, 11, 10,    NEVER, 0, 0},
    '{2, 0, 12, 0,     NEVER, 0, 1},
    '{2, 1, 2,  11,    NEVER, 0, 2},
    '{4, 0, 1,  2,     2,     0, 0},
    '{0, 0, 0,  3,     NEVER, 0, 0},
    '{6, 3, 5,  NEVER, NEVER, 0, 2},
    '{3, 0, 0,  1,     0,     0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] byte_count_i = '0;
  logic din_valid_i = 1'b0;
  logic [7:0] din_data_i = '0;
  logic src_err_i = 1'b0;
  logic tgt_init_i = 1'b0;
  logic tgt_done_i = 1'b0;
  logic din_ready_o, tgt_pwr_en_o, cfg_prog_n_o, cfg_clk_o, cfg_data_o;
  logic busy_o, done_ok_o, err_init_timeout_o, err_done_timeout_o;

  always #2.5 clk = ~clk;

  slave_serial_loader #(
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE), .PROG_CYC(PROG),
    .INIT_POLLS(INIT_P), .DONE_TOGGLES(DONE_T)
  ) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .byte_count_i(byte_count_i),
    .din_valid_i(din_valid_i), .din_data_i(din_data_i), .din_ready_o(din_ready_o),
    .src_err_i(src_err_i), .tgt_init_i(tgt_init_i), .tgt_done_i(tgt_done_i),
    .tgt_pwr_en_o(tgt_pwr_en_o), .cfg_prog_n_o(cfg_prog_n_o), .cfg_clk_o(cfg_clk_o),
    .cfg_data_o(cfg_data_o), .busy_o(busy_o), .done_ok_o(done_ok_o),
    .err_init_timeout_o(err_init_timeout_o), .err_done_timeout_o(err_done_timeout_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // per-run configuration, written by the sequencer before each start
  int cfg_gap, cfg_init_d, cfg_done_m, cfg_err_at, exp_sent;

  // monitor and target/source model state
  logic [7:0] cap [0:15];
  int rises, settle_cnt, prog_cnt, wait_cnt, idx, gap_cnt, setup_viol, hi_viol;
  bit seen_low, presented, prev_cclk, prev_cdata, prev_busy;

  function automatic logic [7:0] exp_byte(input int i);
    logic [7:0] v;
    v = 8'(i * 53 + 167);
    return v ^ 8'(i << 4);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      rises = 0; settle_cnt = 0; prog_cnt = 0; wait_cnt = 0; idx = 0; gap_cnt = 0;
      setup_viol = 0; hi_viol = 0; seen_low = 0; presented = 0;
      prev_cclk = 0; prev_cdata = 0; prev_busy = 0;
      tgt_init_i = 0; tgt_done_i = 0; din_valid_i = 0; src_err_i = 0; din_data_i = '0;
    end else begin
      if (busy_o && !prev_busy) begin
        rises = 0; settle_cnt = 0; prog_cnt = 0; wait_cnt = 0; idx = 0; gap_cnt = 0;
        setup_viol = 0; hi_viol = 0; seen_low = 0; presented = 0;
        tgt_init_i = 0; tgt_done_i = 0;
        for (int i = 0; i < 16; i++) cap[i] = '0;
      end
      prev_busy = busy_o;
      if (busy_o && cfg_prog_n_o && !seen_low) settle_cnt++;
      if (!cfg_prog_n_o) begin seen_low = 1; prog_cnt++; end
      if (seen_low && cfg_prog_n_o && !tgt_init_i) begin
        if (cfg_init_d != NEVER && wait_cnt == cfg_init_d) tgt_init_i = 1;
        wait_cnt++;
      end
      if (cfg_clk_o && !prev_cclk) begin
        if (cfg_data_o != prev_cdata) setup_viol++;
        if (rises < 8 * exp_sent) cap[rises / 8] = {cap[rises / 8][6:0], cfg_data_o};
        rises++;
      end
      if (cfg_clk_o && prev_cclk) hi_viol++;
      prev_cclk = cfg_clk_o;
      prev_cdata = cfg_data_o;
      if (tgt_init_i && cfg_done_m != NEVER && rises >= 8 * exp_sent + cfg_done_m) tgt_done_i = 1;
      // byte source
      if (presented) begin idx++; gap_cnt = 0; end
      presented = 0; din_valid_i = 0; src_err_i = 0;
      if (din_ready_o) begin
        if (idx == cfg_err_at) begin
          src_err_i = 1; din_valid_i = 1; din_data_i = exp_byte(idx);
        end else if (gap_cnt >= cfg_gap) begin
          din_valid_i = 1; din_data_i = exp_byte(idx); presented = 1;
        end else begin
          gap_cnt++;
        end
      end
    end
  end

  task automatic run_case(input int n, input int gap, input int d, input int m,
                          input int ea, input int poke, input int res);
    bit init_ok;
    int sent, pulses, bad, first_act, first_exp;
    string breq;
    init_ok = (d != NEVER) && (d < INIT_P);
    sent = !init_ok ? 0 : ((ea < n) ? ea : n);
    pulses = !init_ok ? 0 : ((m == NEVER || m > DONE_T) ? DONE_T : m);
    cfg_gap = gap; cfg_init_d = d; cfg_done_m = m; cfg_err_at = ea; exp_sent = sent;
    @(negedge clk);
    byte_count_i = CNT_W'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && tgt_pwr_en_o && !done_ok_o && !err_init_timeout_o && !err_done_timeout_o,
        "R8", {busy_o, tgt_pwr_en_o, done_ok_o, err_init_timeout_o, err_done_timeout_o}, 5'b11000);
    for (int k = 0; k < 5000 && busy_o; k++) begin
      if (poke != 0 && k == 40) begin start_i = 1'b1; byte_count_i = CNT_W'(9); end
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(settle_cnt == SETTLE, "R2", settle_cnt, SETTLE);
    chk(prog_cnt == PROG, "R2", prog_cnt, PROG);
    chk(done_ok_o == (res == 0), "R7", done_ok_o, res == 0);
    chk(err_init_timeout_o == (res == 1), "R3", err_init_timeout_o, res == 1);
    chk(err_done_timeout_o == (res == 2), "R7", err_done_timeout_o, res == 2);
    breq = (poke != 0) ? "R9" : (n == 0) ? "R10" : (ea < n) ? "R6" : "R5";
    chk(rises - 8 * sent == pulses, "R7", rises - 8 * sent, pulses);
    chk(rises >= 8 * sent, breq, rises, 8 * sent + pulses);
    bad = 0; first_act = 0; first_exp = 0;
    for (int i = 0; i < sent; i++) begin
      if (cap[i] != exp_byte(i)) begin
        if (bad == 0) begin first_act = cap[i]; first_exp = exp_byte(i); end
        bad++;
      end
    end
    chk(bad == 0, "R4", first_act, first_exp);
    chk(setup_viol == 0 && hi_viol == 0, "R4", setup_viol + hi_viol, 0);
    repeat (3) @(negedge clk);
    chk(!busy_o && (done_ok_o == (res == 0)), "R8", {busy_o, done_ok_o}, {1'b0, res == 0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_gap = 0; cfg_init_d = NEVER; cfg_done_m = NEVER; cfg_err_at = NEVER; exp_sent = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!tgt_pwr_en_o && cfg_prog_n_o && !cfg_clk_o && !cfg_data_o && !busy_o && !din_ready_o
        && !done_ok_o && !err_init_timeout_o && !err_done_timeout_o, "R1",
        {tgt_pwr_en_o, cfg_prog_n_o, cfg_clk_o, cfg_data_o, busy_o}, 5'b01000);
    rst = 1'b0;
    @(negedge clk);
    for (int v = 0; v < NVEC; v++) begin
      run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
    end
    // R1: reset in the middle of shifting returns every output to rest
    cfg_gap = 0; cfg_init_d = 0; cfg_done_m = 0; cfg_err_at = NEVER; exp_sent = 6;
    @(negedge clk);
    byte_count_i = CNT_W'(6);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!tgt_pwr_en_o && cfg_prog_n_o && !cfg_clk_o && !busy_o && !din_ready_o
        && !done_ok_o && !err_init_timeout_o && !err_done_timeout_o, "R1",
        {tgt_pwr_en_o, cfg_prog_n_o, cfg_clk_o, busy_o, din_ready_o}, 5'b01000);
    rst = 1'b0;
    @(negedge clk);
    run_case(2, 0, 0, 1, NEVER, 0, 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule